// File: doc/BRIEF.md
# Latch-Based Output Expander Controller

This block turns a small set of pins into a wide, output-only port. It drives a row of external edge-triggered latches. All the latches share one parallel data bus, and each latch has its own clock line. Software-side logic asks for a single output bit to be set or cleared by giving its bit index and the new value. The block keeps a shadow copy of every latched bit and updates the addressed bit in it. It then places the whole latch group that holds that bit onto the shared bus. After a programmable setup time it pulses the clock of that one latch for a programmable duration.

Only one request is handled at a time. `req_ready` stays low from acceptance until the latch clock has returned low. A request whose index is outside the port is rejected with a one-cycle error flag. The two durations are given in nanoseconds. They are capped at 5000 ns and converted to whole clock cycles, with at least one cycle per phase.

Top module: `lx_expander`

## Requirements
- R1: The port holds N_LATCH × LINES bits, indices 0 to N_LATCH×LINES−1. Bit index k belongs to latch k / LINES (integer division) and to data line k mod LINES of that latch.
- R2: An accepted write changes only the addressed shadow bit. Every other shadow bit keeps its value.
- R3: From the cycle after acceptance, `bus_data[i]` equals shadow bit (g×LINES + i) of the addressed group g, after the update. The bus holds that value until the next accepted write.
- R4: Acceptance happens at a rising edge where `req_valid`, `req_ready` and an in-range index coincide. The addressed latch clock rises exactly S cycles after that edge, with S = max(1, ceil(min(setup_ns, 5000) / CLK_NS)).
- R5: The addressed latch clock stays high for exactly P cycles, with P = max(1, ceil(min(pulse_ns, 5000) / CLK_NS)), and then returns low. No other latch clock rises, and at most one latch clock is high at any time.
- R6: A configured duration above 5000 ns behaves exactly as 5000 ns.
- R7: After reset all latch clocks, all bus lines and the whole shadow are zero, `req_ready` is 1 and `req_err` is 0.
- R8: `dir_out` reports output direction (1) for every bit of the port at all times.
- R9: `req_ready` is low from the cycle after acceptance until the edge at which the latch clock falls. Requests presented while it is low have no effect on the shadow, the bus or the clocks.
- R10: A request with index ≥ N_LATCH×LINES raises `req_err` for exactly the one following cycle. It leaves the shadow, the bus and the clocks unchanged and keeps `req_ready` high.
- R11: The durations are sampled at acceptance; the cycle counts S and P belong to the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_idx | input | IDX_W | Bit index to write |
| req_val | input | 1 | New value of the bit |
| req_ready | output | 1 | Block can take a request |
| req_err | output | 1 | One-cycle flag for an out-of-range index |
| setup_ns | input | 16 | Data setup time before the clock rises, ns |
| pulse_ns | input | 16 | Latch clock high time, ns |
| bus_data | output | LINES | Shared latch data bus |
| latch_clk | output | N_LATCH | One clock line per latch |
| dir_out | output | N_LATCH×LINES | Per-bit direction, 1 = output |

## Verification
The bench writes every index of a 4×4 port and keeps its own shadow model. This catches a wrong group divisor or a wrong line mapping, which would show as a misplaced bus bit or the wrong clock line pulsing. Durations are swept across 0, the round-up boundaries around one clock period and the 5000 ns cap. An off-by-one counter or a missing clamp would show as a clock that rises or falls one cycle early or late, or as a 625-cycle phase growing longer. Requests held active while the block is busy must leave no trace, and indices 16 to 31 must only flag an error. A block that sampled busy requests, or wrapped large indices, would corrupt a shadow bit that the bench later reads back on the bus.

// File: rtl/lx_pkg.sv
package lx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2
  } lx_state_e;

  // nanoseconds -> clock cycles: clamp, round up, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned cap_ns,
                                               input int unsigned period_ns);
    int unsigned lim;
    int unsigned cyc;
    lim = (ns > cap_ns) ? cap_ns : ns;
    cyc = (lim + period_ns - 1) / period_ns;
    if (cyc == 0) cyc = 1;
    return cyc;
  endfunction

endpackage

// File: rtl/lx_shadow.sv
module lx_shadow #(
  parameter int N_LATCH = 4,
  parameter int LINES   = 4,
  parameter int IDX_W   = 5,
  localparam int TOTAL  = N_LATCH * LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] wr_grp,
  input  logic             wr_val,
  output logic [LINES-1:0] bus_q
);

  logic [TOTAL-1:0] shadow_q;
  logic [TOTAL-1:0] shadow_nxt;
  logic [LINES-1:0] group_bits;

  always_comb begin
    shadow_nxt = shadow_q;
    for (int b = 0; b < TOTAL; b++) begin
      if (wr_en && (wr_idx == IDX_W'(b))) shadow_nxt[b] = wr_val;
    end
  end

  always_comb begin
    group_bits = '0;
    for (int g = 0; g < N_LATCH; g++) begin
      if (wr_grp == IDX_W'(g)) group_bits = shadow_nxt[g*LINES +: LINES];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      bus_q    <= '0;
    end else if (wr_en) begin
      shadow_q <= shadow_nxt;
      bus_q    <= group_bits;
    end
  end

  // R2
  shadow_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(shadow_q ^ $past(shadow_q)) <= 1);

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(bus_q));

endmodule

// File: rtl/lx_pulse_seq.sv
module lx_pulse_seq #(
  parameter int N_LATCH = 4,
  parameter int IDX_W   = 5,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   grp,
  input  logic [CNT_W-1:0]   setup_cyc,
  input  logic [CNT_W-1:0]   pulse_cyc,
  output logic               busy,
  output logic               clk_rise_evt,
  output logic               clk_fall_evt,
  output logic [N_LATCH-1:0] latch_clk
);
  import lx_pkg::*;

  lx_state_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   pulse_q;
  logic [IDX_W-1:0]   grp_q;
  logic [N_LATCH-1:0] sel_vec;
  logic               cnt_done;

  for (genvar g = 0; g < N_LATCH; g++) begin : g_sel
    assign sel_vec[g] = (grp_q == IDX_W'(g));
  end

  assign cnt_done     = (cnt_q == '0);
  assign busy         = (st_q != ST_IDLE);
  assign clk_rise_evt = (st_q == ST_SETUP) && cnt_done;
  assign clk_fall_evt = (st_q == ST_PULSE) && cnt_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      pulse_q   <= '0;
      grp_q     <= '0;
      latch_clk <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_SETUP;
          cnt_q   <= setup_cyc - 1'b1;
          pulse_q <= pulse_cyc;
          grp_q   <= grp;
        end
        ST_SETUP: if (cnt_done) begin
          st_q      <= ST_PULSE;
          cnt_q     <= pulse_q - 1'b1;
          latch_clk <= sel_vec;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_PULSE: if (cnt_done) begin
          st_q      <= ST_IDLE;
          latch_clk <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_clk));

  // R9
  clk_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_clk) |-> busy);

  // R4
  rise_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise_evt |=> ($countones(latch_clk) == 1));

  // R5
  fall_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall_evt |=> (latch_clk == '0) && !busy);

endmodule

// File: rtl/lx_expander.sv
module lx_expander #(
  parameter int N_LATCH = 4,
  parameter int LINES   = 4,
  parameter int IDX_W   = 5,
  parameter int CLK_NS  = 8,
  parameter int MAX_NS  = 5000,
  localparam int TOTAL  = N_LATCH * LINES,
  localparam int CNT_W  = $clog2(MAX_NS / CLK_NS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic               req_val,
  output logic               req_ready,
  output logic               req_err,
  input  logic [15:0]        setup_ns,
  input  logic [15:0]        pulse_ns,
  output logic [LINES-1:0]   bus_data,
  output logic [N_LATCH-1:0] latch_clk,
  output logic [TOTAL-1:0]   dir_out
);
  import lx_pkg::*;

  logic             in_range;
  logic             accept_evt;
  logic             reject_evt;
  logic             busy;
  logic             rise_evt;
  logic             fall_evt;
  logic [IDX_W-1:0] grp;
  logic [CNT_W-1:0] setup_cyc;
  logic [CNT_W-1:0] pulse_cyc;

  assign in_range   = ({1'b0, req_idx} < (IDX_W+1)'(TOTAL));
  assign accept_evt = req_valid && req_ready && in_range;
  assign reject_evt = req_valid && req_ready && !in_range;
  assign grp        = req_idx / IDX_W'(LINES);
  assign req_ready  = !busy;
  assign dir_out    = '1;

  assign setup_cyc = CNT_W'(ns_to_cycles(int'(setup_ns), MAX_NS, CLK_NS));
  assign pulse_cyc = CNT_W'(ns_to_cycles(int'(pulse_ns), MAX_NS, CLK_NS));

  always_ff @(posedge clk) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= reject_evt;
  end

  lx_shadow #(.N_LATCH(N_LATCH), .LINES(LINES), .IDX_W(IDX_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept_evt),
    .wr_idx (req_idx),
    .wr_grp (grp),
    .wr_val (req_val),
    .bus_q  (bus_data)
  );

  lx_pulse_seq #(.N_LATCH(N_LATCH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept_evt),
    .grp          (grp),
    .setup_cyc    (setup_cyc),
    .pulse_cyc    (pulse_cyc),
    .busy         (busy),
    .clk_rise_evt (rise_evt),
    .clk_fall_evt (fall_evt),
    .latch_clk    (latch_clk)
  );

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> req_err && req_ready && (latch_clk == '0) && $stable(bus_data));

  // R3
  bus_stable_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_clk) |-> $stable(bus_data));

  // R10
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_err);

endmodule

// File: tb/tb_lx_expander.sv
`timescale 1ns/1ps
module tb_lx_expander;
  localparam int NL = 4;
  localparam int NB = 4;
  localparam int TOT = NL * NB;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic req_val = 1'b0;
  logic req_ready, req_err;
  logic [15:0] setup_ns = '0;
  logic [15:0] pulse_ns = '0;
  logic [NB-1:0] bus_data;
  logic [NL-1:0] latch_clk;
  logic [TOT-1:0] dir_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit model [TOT];

  always #4 clk = ~clk;

  lx_expander #(.N_LATCH(NL), .LINES(NB), .IDX_W(IW), .CLK_NS(8), .MAX_NS(5000)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_val(req_val), .req_ready(req_ready), .req_err(req_err),
    .setup_ns(setup_ns), .pulse_ns(pulse_ns), .bus_data(bus_data),
    .latch_clk(latch_clk), .dir_out(dir_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles from ns: cap 5000, divide by 8 rounding up, never below 1
  function automatic int cyc_of(input int ns);
    int c;
    c = (ns >= 5000) ? 625 : ((ns + 7) >> 3);
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int model_group(input int g);
    int v = 0;
    for (int i = 0; i < NB; i++) v |= int'(model[g*NB + i]) << i;
    return v;
  endfunction

  task automatic do_write(input int idx, input bit v, input int sns, input int pns,
                          input bit inject, input int inj_idx);
    int s, p, g, clk_err, rdy_err, bus_err;
    s = cyc_of(sns);
    p = cyc_of(pns);
    g = idx / NB;
    clk_err = 0; rdy_err = 0; bus_err = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before write", int'(req_ready), 1);
    req_valid = 1'b1; req_idx = IW'(idx); req_val = v;
    setup_ns = 16'(sns); pulse_ns = 16'(pns);
    @(posedge clk);
    model[idx] = v;
    for (int k = 0; k <= s + p; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        // R11: change the durations after acceptance, must not matter
        setup_ns = 16'hFFFF; pulse_ns = 16'd0;
      end
      if (inject && k == 1) begin
        req_valid = 1'b1; req_idx = IW'(inj_idx); req_val = 1'b1;
      end
      if (inject && k == s + p - 1) req_valid = 1'b0;
      if (int'(latch_clk) != ((k >= s && k < s + p) ? (1 << g) : 0)) clk_err++;
      if (req_ready != (k >= s + p)) rdy_err++;
      if (int'(bus_data) != model_group(g)) bus_err++;
    end
    // R1 R4 R5 R11: clock of latch idx/4 high exactly in cycles [S, S+P)
    chk(clk_err == 0, "R1/R4/R5 latch clock timing", clk_err, 0);
    chk(rdy_err == 0, "R9 ready low while busy", rdy_err, 0);
    chk(bus_err == 0, "R2/R3 bus shows group shadow", bus_err, 0);
  endtask

  initial begin
    int durs [11] = '{0, 1, 7, 8, 9, 40, 4999, 5000, 5001, 20000, 65535};
    for (int i = 0; i < TOT; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(req_ready == 1'b1, "R7 ready after reset", int'(req_ready), 1);
    chk(req_err == 1'b0, "R7 err after reset", int'(req_err), 0);
    chk(latch_clk == '0, "R7 clocks after reset", int'(latch_clk), 0);
    chk(bus_data == '0, "R7 bus after reset", int'(bus_data), 0);
    // R8
    chk(dir_out == '1, "R8 all outputs", int'(dir_out), 65535);

    // R1 R2 R3: set every bit in turn, shortest timing
    for (int i = 0; i < TOT; i++) do_write(i, 1'b1, 0, 0, 1'b0, 0);
    // clear odd bits, two-cycle phases
    for (int i = 1; i < TOT; i += 2) do_write(i, 1'b0, 9, 16, 1'b0, 0);
    // R4 R5 R6: duration sweep
    for (int j = 0; j < 11; j++) do_write(5 + (j % 3) * 4, j[0], durs[j], durs[(j + 3) % 11], 1'b0, 0);

    // R9: a held request while busy must be ignored (bit 1 is 0 now)
    do_write(0, 1'b0, 24, 24, 1'b1, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(latch_clk == '0 && req_ready, "R9 no sequence from busy request", int'(latch_clk), 0);
    end
    do_write(2, 1'b1, 0, 0, 1'b0, 0);

    // R10: out-of-range indices
    for (int b = TOT; b < 32; b++) begin
      logic [NB-1:0] bus_before;
      @(negedge clk);
      bus_before = bus_data;
      req_valid = 1'b1; req_idx = IW'(b); req_val = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_err && req_ready && latch_clk == '0 && bus_data == bus_before,
          "R10 reject flag only", int'(req_err), 1);
      @(negedge clk);
      chk(!req_err && latch_clk == '0, "R10 flag one cycle", int'(req_err), 0);
    end
    // R10: shadow untouched, read back through a write in each group
    for (int g = 0; g < NL; g++) do_write(g * NB + 3, 1'b0, 0, 8, 1'b0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule